// File: doc/BRIEF.md
# Multiplexed LCD Common/Segment Scan Sequencer

This block produces the time-multiplexed drive pattern for a segment LCD that has four common lines and thirty-two segment lines. A slow oscillator supplies a one-cycle `tick` strobe. On every tick the sequencer moves its scan position forward. It turns that position, the display register contents and the mode inputs into a 2-bit level code for every common and segment pin. An external analog switch stage uses each code to connect the pin to one of four bias rails.

The number of scanned commons (three or four) and the bias scheme (half or third) are set by input pins and can change at run time. The top four segment pins can be turned into static logic outputs. A display-off input blanks the panel and freezes the scan, but the static outputs keep driving. Each frame is split into two half-frames of opposite polarity, so the panel sees no net DC.

Top module: `lcd_scan_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, the scan sits at the start of a frame: first half-frame, COM1 selected, four-common scanning in force.
- R2: A frame lasts 192 ticks and consists of two half-frames of 96 ticks. Within each half-frame the commons are selected in ascending order. Each row lasts 24 ticks with four commons and 32 ticks with three commons.
- R3: With three-common scanning, COM4 is never selected, and row 4 of the display register never reaches a segment pin.
- R4: Level codes are 0 = ground, 1 = low intermediate, 2 = high intermediate, 3 = full drive. In the first half-frame the selected COM is 3 and the other COMs are 1. In the second half-frame the selected COM is 0 and the other COMs are 2.
- R5: Segment s (0..31) in the active row r reads bit `disp_mem[r*32 + (s/8)*8 + 7 - s%8]`. An ON segment is 0 in the first half-frame and 3 in the second. An OFF segment is 2 in the first half-frame and 1 in the second.
- R6: With `bias_half` high, every level that R4 and R5 give as an intermediate (1 or 2) becomes 2 in both half-frames.
- R7: `port_sel` turns pins into ports as follows: 1 = pin 31, 2 = pins 30..31, 3 = pins 29..31, 4 = pins 28..31; 0, 5, 6 and 7 = none. `port_en[i]` flags pin 28+i.
- R8: A pin set as a port outputs 3 when its row-0 bit is 1 and 0 otherwise, whatever the scan position. Its bits in rows 1..3 have no effect.
- R9: While `disp_on` is low, every COM pin and every non-port SEG pin outputs 0. Port pins keep their R8 value.
- R10: While `disp_on` is low, ticks do not move the scan. When the display is switched back on, the scan resumes from the same position.
- R11: A new value on `duty3` is taken up only when a frame wraps to its start. A change in the middle of a frame leaves the rest of that frame unchanged.
- R12: The scan position changes only on cycles in which `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Oscillator strobe, one clock wide |
| disp_on | input | 1 | Low blanks the LCD outputs and freezes the scan |
| duty3 | input | 1 | 1 = scan three commons, 0 = scan four |
| bias_half | input | 1 | 1 = half bias, 0 = third bias |
| port_sel | input | 3 | Selects how many of the top segment pins act as ports |
| disp_mem | input | 128 | Display register file, 4 rows of 32 bits |
| com_lvl | output | 8 | Level code per common, COM1 in bits 1:0 |
| seg_lvl | output | 64 | Level code per segment, pin s in bits 2s+1:2s |
| port_en | output | 4 | Pins 28..31 that currently act as ports |

## Verification
Every clock cycle the bench compares all outputs against a model. The model tracks only a frame position from 0 to 191 and a latched duty value. The run first uses four-common and then three-common scanning under both bias settings, with two display patterns, so that a wrong row index or a wrong bit order shows up as a different segment level. A duty change is made mid-frame to separate latching at the frame boundary from immediate take-up. A sparse tick pattern shows whether the scan is gated by the tick or runs on the clock. The port codes are stepped through all eight values while the rows 1..3 bits of the shared pins are toggled. A blanking interval with ticks still running checks that the scan freezes and that the ports stay live.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    // Drive level codes handed to the analog switch stage
    typedef enum logic [1:0] {
        LV_VSS  = 2'd0,
        LV_LOW  = 2'd1,
        LV_HIGH = 2'd2,
        LV_TOP  = 2'd3
    } lvl_e;

    localparam int PSEL_W = 3;

endpackage

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer #(
    parameter int FRAME_TICKS = 192,
    parameter int NCOM        = 4,
    localparam int ROW4 = FRAME_TICKS / (2 * NCOM),
    localparam int ROW3 = FRAME_TICKS / (2 * (NCOM - 1)),
    localparam int CW   = $clog2(ROW3),
    localparam int RW   = $clog2(NCOM)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          disp_on,
    input  logic          duty3_in,
    output logic [CW-1:0] cnt_q,
    output logic [RW-1:0] row_q,
    output logic          half_q,
    output logic          duty_q
);

    typedef struct packed {
        logic          duty3;
        logic          half;
        logic [RW-1:0] row;
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [CW-1:0] row_end;
    logic [RW-1:0] last_row;

    always_comb begin
        st_d     = st_q;
        row_end  = st_q.duty3 ? CW'(ROW3 - 1) : CW'(ROW4 - 1);
        last_row = st_q.duty3 ? RW'(NCOM - 2) : RW'(NCOM - 1);
        if (disp_on && tick) begin
            if (st_q.cnt == row_end) begin
                st_d.cnt = '0;
                if (st_q.row == last_row) begin
                    st_d.row  = '0;
                    st_d.half = ~st_q.half;
                    if (st_q.half) begin
                        st_d.duty3 = duty3_in;
                    end
                end else begin
                    st_d.row = st_q.row + RW'(1);
                end
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q  = st_q.cnt;
    assign row_q  = st_q.row;
    assign half_q = st_q.half;
    assign duty_q = st_q.duty3;

endmodule

// File: rtl/lcd_com_drv.sv
module lcd_com_drv
    import lcd_scan_pkg::*;
#(
    parameter int NCOM = 4,
    localparam int RW  = $clog2(NCOM)
) (
    input  logic [RW-1:0]     row,
    input  logic              half,
    input  logic              bias_half,
    input  logic              disp_on,
    output logic [2*NCOM-1:0] com_lvl
);

    for (genvar c = 0; c < NCOM; c++) begin : g_com
        lvl_e lvl;
        always_comb begin
            if (!disp_on) begin
                lvl = LV_VSS;
            end else if (row == RW'(c)) begin
                lvl = half ? LV_VSS : LV_TOP;
            end else if (bias_half) begin
                lvl = LV_HIGH;
            end else begin
                lvl = half ? LV_HIGH : LV_LOW;
            end
        end
        assign com_lvl[2*c +: 2] = lvl;
    end

endmodule

// File: rtl/lcd_seg_drv.sv
module lcd_seg_drv
    import lcd_scan_pkg::*;
#(
    parameter int NCOM  = 4,
    parameter int NSEG  = 32,
    parameter int NPORT = 4,
    localparam int RW   = $clog2(NCOM)
) (
    input  logic [NCOM*NSEG-1:0] disp_mem,
    input  logic [RW-1:0]        row,
    input  logic                 half,
    input  logic                 bias_half,
    input  logic                 disp_on,
    input  logic [PSEL_W-1:0]    port_sel,
    output logic [2*NSEG-1:0]    seg_lvl,
    output logic [NPORT-1:0]     port_en
);

    logic [NSEG-1:0] act_bits;
    int              nports;

    assign act_bits = disp_mem[int'(row) * NSEG +: NSEG];

    always_comb begin
        if (port_sel >= PSEL_W'(1) && int'(port_sel) <= NPORT) begin
            nports = int'(port_sel);
        end else begin
            nports = 0;
        end
        for (int i = 0; i < NPORT; i++) begin
            port_en[i] = (i >= NPORT - nports);
        end
    end

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        localparam int BP = (s / 8) * 8 + 7 - (s % 8);
        logic is_port;
        lvl_e lvl;

        if (s >= NSEG - NPORT) begin : g_shared
            assign is_port = port_en[s - (NSEG - NPORT)];
        end else begin : g_plain
            assign is_port = 1'b0;
        end

        always_comb begin
            if (is_port) begin
                lvl = disp_mem[BP] ? LV_TOP : LV_VSS;
            end else if (!disp_on) begin
                lvl = LV_VSS;
            end else if (act_bits[BP]) begin
                lvl = half ? LV_TOP : LV_VSS;
            end else if (bias_half) begin
                lvl = LV_HIGH;
            end else begin
                lvl = half ? LV_LOW : LV_HIGH;
            end
        end
        assign seg_lvl[2*s +: 2] = lvl;
    end

endmodule

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq
    import lcd_scan_pkg::*;
#(
    parameter int NCOM        = 4,
    parameter int NSEG        = 32,
    parameter int NPORT       = 4,
    parameter int FRAME_TICKS = 192
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 disp_on,
    input  logic                 duty3,
    input  logic                 bias_half,
    input  logic [PSEL_W-1:0]    port_sel,
    input  logic [NCOM*NSEG-1:0] disp_mem,
    output logic [2*NCOM-1:0]    com_lvl,
    output logic [2*NSEG-1:0]    seg_lvl,
    output logic [NPORT-1:0]     port_en
);

    localparam int ROW3 = FRAME_TICKS / (2 * (NCOM - 1));
    localparam int CW   = $clog2(ROW3);
    localparam int RW   = $clog2(NCOM);

    logic [CW-1:0] t_cnt;
    logic [RW-1:0] t_row;
    logic          t_half;
    logic          t_duty;

    lcd_scan_timer #(.FRAME_TICKS(FRAME_TICKS), .NCOM(NCOM)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .disp_on  (disp_on),
        .duty3_in (duty3),
        .cnt_q    (t_cnt),
        .row_q    (t_row),
        .half_q   (t_half),
        .duty_q   (t_duty)
    );

    lcd_com_drv #(.NCOM(NCOM)) u_com (
        .row       (t_row),
        .half      (t_half),
        .bias_half (bias_half),
        .disp_on   (disp_on),
        .com_lvl   (com_lvl)
    );

    lcd_seg_drv #(.NCOM(NCOM), .NSEG(NSEG), .NPORT(NPORT)) u_seg (
        .disp_mem  (disp_mem),
        .row       (t_row),
        .half      (t_half),
        .bias_half (bias_half),
        .disp_on   (disp_on),
        .port_sel  (port_sel),
        .seg_lvl   (seg_lvl),
        .port_en   (port_en)
    );

endmodule

// File: rtl/lcd_scan_chk.sv
module lcd_scan_chk #(
    parameter int NCOM        = 4,
    parameter int FRAME_TICKS = 192,
    localparam int ROW4 = FRAME_TICKS / (2 * NCOM),
    localparam int ROW3 = FRAME_TICKS / (2 * (NCOM - 1)),
    localparam int CW   = $clog2(ROW3),
    localparam int RW   = $clog2(NCOM)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              disp_on,
    input logic [2*NCOM-1:0] com_lvl,
    input logic [CW-1:0]     cnt_q,
    input logic [RW-1:0]     row_q,
    input logic              half_q,
    input logic              duty_q
);

    logic [NCOM-1:0] com_ext;
    always_comb begin
        for (int c = 0; c < NCOM; c++) begin
            com_ext[c] = (com_lvl[2*c +: 2] == 2'd3) || (com_lvl[2*c +: 2] == 2'd0);
        end
    end

    // R2
    row_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) < (duty_q ? ROW3 : ROW4));

    // R3
    no_last_com_chk: assert property (@(posedge clk) disable iff (!rst_n)
        duty_q |-> (int'(row_q) != NCOM - 1));

    // R4
    one_com_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_on |-> ($countones(com_ext) == 1));

    // R9
    com_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_on |-> (com_lvl == '0));

    // R10
    off_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_on |=> ($stable(cnt_q) && $stable(row_q) && $stable(half_q) && $stable(duty_q)));

    // R11
    duty_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(duty_q) |-> (cnt_q == '0 && row_q == '0 && !half_q));

    // R12
    tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(cnt_q) && $stable(row_q) && $stable(half_q)));

endmodule

bind lcd_scan_seq lcd_scan_chk #(.NCOM(NCOM), .FRAME_TICKS(FRAME_TICKS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .disp_on (disp_on),
    .com_lvl (com_lvl),
    .cnt_q   (t_cnt),
    .row_q   (t_row),
    .half_q  (t_half),
    .duty_q  (t_duty)
);

// File: tb/lcd_scan_seq_test.sv
module lcd_scan_seq_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         disp_on = 1'b1;
    logic         duty3 = 1'b0;
    logic         bias_half = 1'b0;
    logic [2:0]   port_sel = 3'd0;
    logic [127:0] disp_mem = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    logic [7:0]   com_lvl;
    logic [63:0]  seg_lvl;
    logic [3:0]   port_en;

    int total = 0;
    int bad = 0;
    bit run_chk = 1'b0;
    bit tick_en = 1'b0;
    int tick_div = 1;
    int tphase = 0;

    // behavioural model state
    int m_pos = 0;
    bit m_duty3 = 1'b0;

    lcd_scan_seq uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .disp_on(disp_on),
        .duty3(duty3), .bias_half(bias_half), .port_sel(port_sel),
        .disp_mem(disp_mem), .com_lvl(com_lvl), .seg_lvl(seg_lvl),
        .port_en(port_en)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #2;
        tphase = tphase + 1;
        tick = tick_en && (tphase % tick_div == 0);
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pos = 0;
            m_duty3 = 1'b0;
        end else if (disp_on && tick) begin
            m_pos = (m_pos + 1) % 192;
            if (m_pos == 0) m_duty3 = duty3;
        end
    end

    function automatic bit pin_is_port(input int s);
        case (port_sel)
            3'd1: return s == 31;
            3'd2: return s == 30 || s == 31;
            3'd3: return s == 29 || s == 30 || s == 31;
            3'd4: return s >= 28;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [1:0] mid(input bit hf, input bit for_com);
        if (bias_half) return 2'd2;
        if (for_com) return hf ? 2'd2 : 2'd1;
        return hf ? 2'd1 : 2'd2;
    endfunction

    always @(negedge clk) begin
        if (run_chk) begin
            int rl;
            int mrow;
            bit mhalf;
            logic [7:0] ec;
            logic [63:0] es;
            logic [3:0] ep;
            rl = m_duty3 ? 32 : 24;
            mrow = (m_pos % 96) / rl;
            mhalf = (m_pos >= 96);
            for (int c = 0; c < 4; c++) begin
                if (!disp_on) ec[2*c +: 2] = 2'd0;
                else if (c == mrow) ec[2*c +: 2] = mhalf ? 2'd0 : 2'd3;
                else ec[2*c +: 2] = mid(mhalf, 1'b1);
            end
            for (int s = 0; s < 32; s++) begin
                bit on;
                on = disp_mem[(mrow * 4 + s / 8) * 8 + 7 - (s % 8)];
                if (pin_is_port(s)) es[2*s +: 2] = disp_mem[(s / 8) * 8 + 7 - (s % 8)] ? 2'd3 : 2'd0;
                else if (!disp_on) es[2*s +: 2] = 2'd0;
                else if (on) es[2*s +: 2] = mhalf ? 2'd3 : 2'd0;
                else es[2*s +: 2] = mid(mhalf, 1'b0);
            end
            for (int i = 0; i < 4; i++) ep[i] = pin_is_port(28 + i);
            chk("R2 R3 R4 R6 R10 R11 R12 com", {56'd0, com_lvl}, {56'd0, ec});
            chk("R5 R6 R8 R9 seg", seg_lvl, es);
            chk("R7 port_en", {60'd0, port_en}, {60'd0, ep});
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        #1_500_000;
        bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] saved_com;
        step(1);
        run_chk = 1'b1;
        step(2);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: COM1 selected, first half, third bias
        chk("R1 reset com", {56'd0, com_lvl}, {56'd0, 8'b01_01_01_11});
        step(1);
        tick_en = 1'b1;
        step(500);
        disp_mem = 128'hA5C3_0FF0_1E2D_3C4B_5A69_7887_96A5_B4C3;
        step(300);
        duty3 = 1'b1;              // R11 mid-frame request
        step(700);
        bias_half = 1'b1;          // R6
        step(450);
        bias_half = 1'b0;
        for (int p = 0; p < 8; p++) begin
            port_sel = 3'(p);
            step(120);
            disp_mem[3*32 + 31 -: 8] ^= 8'h0F;   // rows 1..3 of shared pins, R8
            disp_mem[2*32 + 31 -: 8] ^= 8'h0F;
            disp_mem[1*32 + 31 -: 8] ^= 8'h0F;
            step(130);
            @(negedge clk);
            // R8: port pins follow row-0 bits 3..0 of byte 3
            for (int i = 0; i < 4; i++) begin
                if (pin_is_port(28 + i))
                    chk("R8 port pin", {62'd0, seg_lvl[2*(28+i) +: 2]},
                        {62'd0, disp_mem[24 + 3 - i] ? 2'd3 : 2'd0});
            end
        end
        port_sel = 3'd3;
        step(37);
        @(negedge clk);
        saved_com = com_lvl;
        step(0);
        disp_on = 1'b0;
        step(150);
        @(negedge clk);
        chk("R9 blank com", {56'd0, com_lvl}, 64'd0);
        step(0);
        disp_on = 1'b1;
        @(negedge clk);
        chk("R10 resume com", {56'd0, com_lvl}, {56'd0, saved_com});
        tick_div = 3;              // R12 sparse ticks
        step(1300);
        duty3 = 1'b0;
        step(900);
        tick_div = 1;
        step(400);
        disp_on = 1'b0;
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        disp_on = 1'b1;
        @(negedge clk);
        chk("R1 reset during off", {56'd0, com_lvl}, {56'd0, 8'b01_01_01_11});
        step(200);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule